// File: doc/BRIEF.md
# Parallel RGB Panel Timing Generator

This block drives a parallel RGB display panel. It makes the horizontal sync, vertical sync and data-enable strobes, the current pixel column and row, and a pixel bus. All of these follow a set of packed 32-bit configuration words that arrive through a simple write port. Most length fields in those words hold the real length minus one. The vertical back porch is the exception and holds its real length.

A pixel strobe comes from a fractional divider. On every clock it adds one, or two when the doubled source is selected, to an accumulator. When the sum reaches the divisor, a pixel period ends. Divisors of 0 and 1 act as 2.

Pixel data comes in on a valid/ready stream. The block raises ready only on a pixel strobe that falls inside the active area, so one beat is taken per visible pixel. Back-pressure is one-sided: the block never waits for the source. An active pixel that finds valid low is sent as black. Configuration writes go into a staging copy. That copy becomes the working copy only when the last pixel of a frame is emitted.

Top module: `lcd_timing_gen`

## Requirements
- R1: While reset is held and right after it, lcd_de, lcd_hsync, lcd_vsync, lcd_pclk_en, lcd_x, lcd_y and lcd_rgb are all 0. The working configuration resets to all-zero words, so the first frame is 4 pixels by 3 lines with divisor 2.
- R2: Word 0 bit 0 selects the doubled source and bits 15:8 hold the divisor D. Each clock the accumulator gains 1, or 2 when doubled. A pixel strobe fires when the sum is at least D, and D is then subtracted. lcd_pclk_en is high for one clock, one cycle after each strobe.
- R3: A divisor field of 0 or 1 behaves exactly like 2.
- R4: A line runs active, front porch, sync, back porch. Active width is word 4[15:0]+1, front porch is word 3[15:0]+1, sync is word 1[15:0]+1 and back porch is word 3[31:16]+1. lcd_hsync is high during the sync pixels when its polarity is 0.
- R5: A frame runs active lines, front porch, sync, back porch. Active height is word 4[31:16]+1, front porch is word 2[15:0]+1, sync is word 1[31:16]+1 and back porch is word 2[31:16] with no bias (0 is allowed). lcd_vsync is high on the sync lines when its polarity is 0.
- R6: lcd_de is 1 only for pixels inside both the active width and the active height. lcd_x and lcd_y give the column and row of such a pixel and are 0 otherwise.
- R7: Word 5 bit 0 inverts lcd_hsync and word 5 bit 1 inverts lcd_vsync, which makes each one active-low.
- R8: Word 5 bits 9:8 choose the output format: 0 is 4-4-4, 1 is 5-6-5, 2 is 6-6-6 and 3 is 8-8-8. Red sits in [23:16], green in [15:8] and blue in [7:0]. The unused low bits of each channel read as 0 on lcd_rgb.
- R9: pix_ready is high only in a clock where a pixel strobe falls on an active pixel. The beat taken in that clock appears masked on lcd_rgb. When valid is low, or the pixel is not active, lcd_rgb shows 0.
- R10: Writes change only the staging copy. The working copy, the divider accumulator and the counters restart together on the strobe that emits the last pixel of a frame.
- R11: Writes to addresses 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 3 | Configuration word index |
| cfg_wr_data | input | 32 | Configuration word value |
| pix_valid | input | 1 | Input pixel stream valid |
| pix_ready | output | 1 | Input pixel stream ready |
| pix_data | input | 24 | Input pixel, R[23:16] G[15:8] B[7:0] |
| lcd_pclk_en | output | 1 | Pixel strobe, one clock per pixel |
| lcd_hsync | output | 1 | Horizontal sync after polarity |
| lcd_vsync | output | 1 | Vertical sync after polarity |
| lcd_de | output | 1 | Data enable |
| lcd_x | output | 16 | Active column |
| lcd_y | output | 16 | Active row |
| lcd_rgb | output | 24 | Masked pixel bus |

## Verification
pix_ready is combinational, so it is due in the same clock as the strobe. Every panel output is registered on the strobe edge and is due one clock later, and it then holds until the next strobe. A configuration write shows up only after the edge that carries a frame's last pixel.

The reference model steps once on each rising edge, in the same order as the hardware. It takes the outputs using the old working copy, then reloads from staging, then applies the write. The bench compares every output at the falling edge, so each expected value is already settled when it is sampled.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int NUM_WORDS = 6;
  localparam int W_CLK     = 0;
  localparam int W_SYNC    = 1;
  localparam int W_VPORCH  = 2;
  localparam int W_HPORCH  = 3;
  localparam int W_ACTIVE  = 4;
  localparam int W_OUT     = 5;

  typedef enum logic [1:0] {
    FMT_444 = 2'd0,
    FMT_565 = 2'd1,
    FMT_666 = 2'd2,
    FMT_888 = 2'd3
  } out_fmt_e;

  function automatic logic [23:0] fmt_mask(input out_fmt_e fmt);
    logic [23:0] m;
    case (fmt)
      FMT_444: m = 24'hF0F0F0;
      FMT_565: m = 24'hF8FCF8;
      FMT_666: m = 24'hFCFCFC;
      default: m = 24'hFFFFFF;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/lcd_tg_cfg.sv
module lcd_tg_cfg
  import lcd_tg_pkg::*;
#(
  parameter int FW    = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             load,
  output logic             clk_dbl,
  output logic [DIV_W-1:0] div_raw,
  output logic [FW-1:0]    hsync_m1,
  output logic [FW-1:0]    vsync_m1,
  output logic [FW-1:0]    vfp_m1,
  output logic [FW-1:0]    vbp,
  output logic [FW-1:0]    hfp_m1,
  output logic [FW-1:0]    hbp_m1,
  output logic [FW-1:0]    width_m1,
  output logic [FW-1:0]    height_m1,
  output logic             hpol,
  output logic             vpol,
  output out_fmt_e         fmt
);
  logic [31:0] stage  [NUM_WORDS];
  logic [31:0] active [NUM_WORDS];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage[i]  <= '0;
        active[i] <= '0;
      end else begin
        if (load) active[i] <= stage[i];
        if (wr_en && (32'(wr_addr) == i)) stage[i] <= wr_data;
      end
    end
  end

  assign clk_dbl   = active[W_CLK][0];
  assign div_raw   = active[W_CLK][8 +: DIV_W];
  assign hsync_m1  = active[W_SYNC][0 +: FW];
  assign vsync_m1  = active[W_SYNC][16 +: FW];
  assign vfp_m1    = active[W_VPORCH][0 +: FW];
  assign vbp       = active[W_VPORCH][16 +: FW];
  assign hfp_m1    = active[W_HPORCH][0 +: FW];
  assign hbp_m1    = active[W_HPORCH][16 +: FW];
  assign width_m1  = active[W_ACTIVE][0 +: FW];
  assign height_m1 = active[W_ACTIVE][16 +: FW];
  assign hpol      = active[W_OUT][0];
  assign vpol      = active[W_OUT][1];
  assign fmt       = out_fmt_e'(active[W_OUT][9:8]);
endmodule

// File: rtl/lcd_tg_pixdiv.sv
module lcd_tg_pixdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbl,
  input  logic [DIV_W-1:0] div_raw,
  input  logic             restart,
  output logic             tick
);
  localparam int AW = DIV_W + 1;
  logic [AW-1:0] acc, sum, div_eff;

  assign div_eff = (div_raw < DIV_W'(2)) ? AW'(2) : {1'b0, div_raw};
  assign sum     = acc + (dbl ? AW'(2) : AW'(1));
  assign tick    = (sum >= div_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc <= '0;
    else if (restart) acc <= '0;
    else if (tick)    acc <= sum - div_eff;
    else              acc <= sum;
  end
endmodule

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis #(
  parameter int CW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [CW-1:0] act_len,
  input  logic [CW-1:0] fp_len,
  input  logic [CW-1:0] sync_len,
  input  logic [CW-1:0] bp_len,
  output logic [CW-1:0] pos,
  output logic          in_act,
  output logic          in_sync,
  output logic          at_end
);
  logic [CW-1:0] sync_start, sync_stop, total;

  assign sync_start = act_len + fp_len;
  assign sync_stop  = sync_start + sync_len;
  assign total      = sync_stop + bp_len;
  assign in_act     = (pos < act_len);
  assign in_sync    = (pos >= sync_start) && (pos < sync_stop);
  assign at_end     = (pos >= total - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos <= '0;
    else if (step) pos <= at_end ? '0 : pos + CW'(1);
  end
endmodule

// File: rtl/lcd_tg_out.sv
module lcd_tg_out
  import lcd_tg_pkg::*;
#(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          act,
  input  logic          hs_raw,
  input  logic          vs_raw,
  input  logic          hpol,
  input  logic          vpol,
  input  out_fmt_e      fmt,
  input  logic [FW-1:0] col,
  input  logic [FW-1:0] row,
  input  logic          px_valid,
  input  logic [23:0]   px_data,
  output logic          pclk_en,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [FW-1:0] x,
  output logic [FW-1:0] y,
  output logic [23:0]   rgb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_en <= 1'b0;
      hsync   <= 1'b0;
      vsync   <= 1'b0;
      de      <= 1'b0;
      x       <= '0;
      y       <= '0;
      rgb     <= '0;
    end else begin
      pclk_en <= tick;
      if (tick) begin
        hsync <= hs_raw ^ hpol;
        vsync <= vs_raw ^ vpol;
        de    <= act;
        x     <= act ? col : '0;
        y     <= act ? row : '0;
        rgb   <= (act && px_valid) ? (px_data & fmt_mask(fmt)) : 24'h0;
      end
    end
  end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int FW    = 16,
  parameter int DIV_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_en,
  input  logic [2:0]    cfg_wr_addr,
  input  logic [31:0]   cfg_wr_data,
  input  logic          pix_valid,
  output logic          pix_ready,
  input  logic [23:0]   pix_data,
  output logic          lcd_pclk_en,
  output logic          lcd_hsync,
  output logic          lcd_vsync,
  output logic          lcd_de,
  output logic [FW-1:0] lcd_x,
  output logic [FW-1:0] lcd_y,
  output logic [23:0]   lcd_rgb
);
  localparam int CW = FW + 2;

  logic             act_clk_dbl, hpol, vpol;
  logic [DIV_W-1:0] div_raw;
  logic [FW-1:0]    hsync_m1, vsync_m1, vfp_m1, vbp, hfp_m1, hbp_m1, width_m1, height_m1;
  out_fmt_e         fmt;
  logic             tick, frame_load;
  logic [CW-1:0]    hpos, vpos;
  logic             h_act, h_sync, h_end, v_act, v_sync, v_end;

  function automatic logic [CW-1:0] ext(input logic [FW-1:0] f, input logic bias);
    return {{(CW-FW){1'b0}}, f} + CW'(bias);
  endfunction

  assign frame_load = tick && h_end && v_end;

  lcd_tg_cfg #(.FW(FW), .DIV_W(DIV_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr),
    .wr_data(cfg_wr_data), .load(frame_load), .clk_dbl(act_clk_dbl),
    .div_raw(div_raw), .hsync_m1(hsync_m1), .vsync_m1(vsync_m1),
    .vfp_m1(vfp_m1), .vbp(vbp), .hfp_m1(hfp_m1), .hbp_m1(hbp_m1),
    .width_m1(width_m1), .height_m1(height_m1), .hpol(hpol), .vpol(vpol),
    .fmt(fmt)
  );

  lcd_tg_pixdiv #(.DIV_W(DIV_W)) div_i (
    .clk(clk), .rst_n(rst_n), .dbl(act_clk_dbl), .div_raw(div_raw),
    .restart(frame_load), .tick(tick)
  );

  lcd_tg_axis #(.CW(CW)) h_axis_i (
    .clk(clk), .rst_n(rst_n), .step(tick),
    .act_len(ext(width_m1, 1'b1)), .fp_len(ext(hfp_m1, 1'b1)),
    .sync_len(ext(hsync_m1, 1'b1)), .bp_len(ext(hbp_m1, 1'b1)),
    .pos(hpos), .in_act(h_act), .in_sync(h_sync), .at_end(h_end)
  );

  lcd_tg_axis #(.CW(CW)) v_axis_i (
    .clk(clk), .rst_n(rst_n), .step(tick && h_end),
    .act_len(ext(height_m1, 1'b1)), .fp_len(ext(vfp_m1, 1'b1)),
    .sync_len(ext(vsync_m1, 1'b1)), .bp_len(ext(vbp, 1'b0)),
    .pos(vpos), .in_act(v_act), .in_sync(v_sync), .at_end(v_end)
  );

  assign pix_ready = tick && h_act && v_act;

  lcd_tg_out #(.FW(FW)) out_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .act(h_act && v_act),
    .hs_raw(h_sync), .vs_raw(v_sync), .hpol(hpol), .vpol(vpol), .fmt(fmt),
    .col(hpos[FW-1:0]), .row(vpos[FW-1:0]), .px_valid(pix_valid),
    .px_data(pix_data), .pclk_en(lcd_pclk_en), .hsync(lcd_hsync),
    .vsync(lcd_vsync), .de(lcd_de), .x(lcd_x), .y(lcd_y), .rgb(lcd_rgb)
  );
endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk #(
  parameter int FW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_ready,
  input logic          lcd_pclk_en,
  input logic          lcd_de,
  input logic          lcd_hsync,
  input logic          lcd_vsync,
  input logic [FW-1:0] lcd_x,
  input logic [FW-1:0] lcd_y,
  input logic [23:0]   lcd_rgb,
  input logic          clk_dbl
);
  p_ready_gives_de_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |=> (lcd_de && lcd_pclk_en));

  p_pos_zero_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_de |-> (lcd_x == '0 && lcd_y == '0));

  p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_pclk_en |-> ($stable(lcd_de) && $stable(lcd_hsync) && $stable(lcd_vsync) && $stable(lcd_rgb)));

  p_min_div_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_pclk_en && !clk_dbl) |=> !lcd_pclk_en);

  p_rgb_zero_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_de |-> (lcd_rgb == 24'h0));
endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(.FW(FW)) chk_i (
  .clk(clk), .rst_n(rst_n), .pix_ready(pix_ready), .lcd_pclk_en(lcd_pclk_en),
  .lcd_de(lcd_de), .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync),
  .lcd_x(lcd_x), .lcd_y(lcd_y), .lcd_rgb(lcd_rgb), .clk_dbl(act_clk_dbl)
);

// File: tb/lcd_timing_gen_tb.sv
`timescale 1ns/1ps
module lcd_timing_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [2:0]  cfg_wr_addr = '0;
  logic [31:0] cfg_wr_data = '0;
  logic        pix_valid = 1'b0;
  logic [23:0] pix_data = '0;
  logic        pix_ready, lcd_pclk_en, lcd_hsync, lcd_vsync, lcd_de;
  logic [15:0] lcd_x, lcd_y;
  logic [23:0] lcd_rgb;

  always #4 clk = ~clk;

  lcd_timing_gen dut_i (.*);

  int checks = 0, errors = 0;
  string phase = "R1";
  bit chk_en = 0, done = 0;

  // reference model state
  int stg[8], act[8];
  int h, v, acc;
  int e_de, e_hs, e_vs, e_x, e_y, e_rgb, e_tick, e_ready;

  function automatic int fld(int w, int hi);
    return hi ? ((w >>> 16) & 16'hFFFF) : (w & 16'hFFFF);
  endfunction

  function automatic int mask_of(int mode);
    case (mode)
      0: return 24'hF0F0F0;
      1: return 24'hF8FCF8;
      2: return 24'hFCFCFC;
      default: return 24'hFFFFFF;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin stg[i] = 0; act[i] = 0; end
    h = 0; v = 0; acc = 0;
    e_de = 0; e_hs = 0; e_vs = 0; e_x = 0; e_y = 0; e_rgb = 0; e_tick = 0; e_ready = 0;
  endtask

  task automatic model_step();
    int W, HF, HS, HB, Ht, V, VF, VS, VB, Vt, dv, inc, sum;
    bit tk, act_px, wrap;
    W = fld(act[4],0)+1; HF = fld(act[3],0)+1; HS = fld(act[1],0)+1; HB = fld(act[3],1)+1;
    V = fld(act[4],1)+1; VF = fld(act[2],0)+1; VS = fld(act[1],1)+1; VB = fld(act[2],1);
    Ht = W+HF+HS+HB; Vt = V+VF+VS+VB;
    dv = (act[0] >>> 8) & 8'hFF; if (dv < 2) dv = 2;
    inc = (act[0] & 1) ? 2 : 1;
    sum = acc + inc; tk = (sum >= dv); acc = tk ? sum - dv : sum;
    e_tick = tk; wrap = 0;
    if (tk) begin
      act_px = (h < W) && (v < V);
      e_de = act_px;
      e_hs = ((h >= W+HF) && (h < W+HF+HS)) ^ (act[5] & 1);
      e_vs = ((v >= V+VF) && (v < V+VF+VS)) ^ ((act[5] >>> 1) & 1);
      e_x = act_px ? h : 0; e_y = act_px ? v : 0;
      e_rgb = (act_px && pix_valid) ? (int'(pix_data) & mask_of((act[5] >>> 8) & 3)) : 0;
      if (h == Ht-1) begin
        h = 0;
        if (v == Vt-1) begin v = 0; wrap = 1; end else v++;
      end else h++;
    end
    if (wrap) begin // R10: reload staged words at frame end
      for (int i = 0; i < 6; i++) act[i] = stg[i];
      acc = 0;
    end
    if (cfg_wr_en && cfg_wr_addr < 6) stg[cfg_wr_addr] = int'(cfg_wr_data); // R11
    // predict combinational ready for next cycle
    W = fld(act[4],0)+1; V = fld(act[4],1)+1;
    dv = (act[0] >>> 8) & 8'hFF; if (dv < 2) dv = 2;
    inc = (act[0] & 1) ? 2 : 1;
    e_ready = ((acc + inc) >= dv) && (h < W) && (v < V);
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  task automatic chk(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s phase=%s t=%0t actual=%0h expected=%0h", req, phase, $time, actual, expected);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && rst_n) begin
      chk("R2 pclk_en", lcd_pclk_en, e_tick);
      chk("R4 hsync", lcd_hsync, e_hs);
      chk("R5 vsync", lcd_vsync, e_vs);
      chk("R6 de", lcd_de, e_de);
      chk("R6 x", lcd_x, e_x);
      chk("R6 y", lcd_y, e_y);
      chk("R8 rgb", lcd_rgb, e_rgb);
      chk("R9 ready", pix_ready, e_ready);
    end
  end

  // input pixel stream pattern
  int lfsr = 32'h1ACE5;
  always @(negedge clk) begin
    lfsr = (lfsr << 1) ^ (((lfsr >>> 31) ^ (lfsr >>> 21) ^ (lfsr >>> 1) ^ lfsr) & 1);
    pix_data  <= 24'(lfsr * 32'h9E37);
    pix_valid <= (lfsr & 7) != 0;
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_wr_en <= 1'b1; cfg_wr_addr <= 3'(a); cfg_wr_data <= 32'(d);
    @(negedge clk);
    cfg_wr_en <= 1'b0;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 de", lcd_de, 0); chk("R1 hsync", lcd_hsync, 0); chk("R1 vsync", lcd_vsync, 0);
    chk("R1 pclk_en", lcd_pclk_en, 0); chk("R1 rgb", lcd_rgb, 0); chk("R1 x", lcd_x, 0);
    rst_n = 1'b1;
    chk_en = 1;
    phase = "R3_default";
    run(200);
    phase = "R4_R5_cfgA";
    wr(4, (2 << 16) | 5);
    wr(3, (1 << 16) | 1);
    wr(1, (1 << 16) | 1);
    wr(2, (0 << 16) | 0);
    wr(0, (3 << 8));
    wr(5, 3 << 8);
    run(1500);
    phase = "R10_R7_cfgB";
    wr(0, (2 << 8) | 1);
    wr(5, (1 << 8) | 3);
    wr(2, (2 << 16) | 1);
    run(1500);
    phase = "R3_R11_cfgC";
    wr(0, (1 << 8));
    wr(5, (0 << 8) | 1);
    wr(6, 32'h0000_0701);
    wr(7, 32'hFFFF_FFFF);
    run(1500);
    phase = "R2_R8_cfgD";
    wr(0, (5 << 8) | 1);
    wr(5, (2 << 8) | 2);
    wr(4, (1 << 16) | 3);
    run(1500);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog phase=%s actual=hung expected=done", phase);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule